// File: doc/BRIEF.md
# Floppy Drive Control Register

This block is the host-writable drive control register of a floppy disk controller. One write sets four things: which of the four drives is selected, which spindle motors run, whether the controller core is held in soft reset, and whether the DMA request and interrupt paths reach the host bus. Reads return the whole register unchanged.

The drive number field is decoded into one-hot, active-low drive-select pins. The motor bits drive active-low motor pins. Both sets of pins pass through an output flop stage. The soft-reset bit drives an active-low reset to the controller core. That reset holds until software writes the bit back to 1. It never clears the register itself. Only the hardware reset does that.

A mode input selects AT-compatible or PS/2-compatible behaviour for the DMA and interrupt gating. In AT mode the DMA-enable bit decides whether DRQ and the interrupt are driven and whether DACK and TC reach the core. In PS/2 mode these paths are always open. Pins that would float are modelled with a separate output-enable for each pin.

Top module: `fdc_drive_ctl`

## Requirements
- R1: While `rst_ni` is low, every register bit is 0, `rdata_o` is 0x00, `core_rst_no` is 0, `drv_sel_no` is 4'b1110 and `motor_no` is 4'b1111.
- R2: A write is accepted in any cycle, including while the soft reset is asserted. `rdata_o` shows the written byte from the clock edge that samples `wr_en_i` onward.
- R3: Register bits 1:0 hold a binary drive number n. One clock after the register changes, `drv_sel_no[n]` is 0 and the other three drive-select pins are 1, so exactly one pin is low.
- R4: Register bits 7:4 enable motors 3..0 (bit 4+k for motor k). One clock after the register changes, `motor_no[k]` is the inverse of bit 4+k.
- R5: Register bit 2 is an active-low core reset. `core_rst_no` equals bit 2 from the edge that writes it, and it stays 0 until a 1 is written to that bit.
- R6: A soft reset (bit 2 = 0) changes no register bit other than by the write itself. Two writes in consecutive cycles, first with bit 2 = 0 and then with bit 2 = 1, produce a core reset pulse exactly one cycle wide.
- R7: In AT mode (`ps2_mode_i` = 0), register bit 3 set gives `drq_oe_o` = `int_oe_o` = 1, `drq_o` = `drq_i`, `int_o` = `int_i`, `dack_core_no` = `dack_ni` and `tc_core_o` = `tc_i`. Bit 3 clear gives both enables 0, `drq_o` = `int_o` = 0, `dack_core_no` = 1 and `tc_core_o` = 0.
- R8: In PS/2 mode (`ps2_mode_i` = 1), all four paths pass as for bit 3 set, whatever bit 3 holds and also during hardware reset. Bit 3 still reads 0 after a hardware reset.
- R9: The bytes 0x1C, 0x2D, 0x4E and 0x8F each select drive n and run only motor n (n = 0..3), with DMA enabled and the core out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| ps2_mode_i | input | 1 | 1 = PS/2-compatible gating, 0 = AT-compatible |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current register contents |
| core_rst_no | output | 1 | Active-low reset to controller core |
| drv_sel_no | output | 4 | Active-low one-hot drive selects |
| motor_no | output | 4 | Active-low motor enables |
| drq_i | input | 1 | DMA request from the core |
| drq_o | output | 1 | DMA request pin value |
| drq_oe_o | output | 1 | DMA request pin enable |
| int_i | input | 1 | Interrupt from the core |
| int_o | output | 1 | Interrupt pin value |
| int_oe_o | output | 1 | Interrupt pin enable |
| dack_ni | input | 1 | Active-low DMA acknowledge from the host |
| dack_core_no | output | 1 | Gated DMA acknowledge to the core |
| tc_i | input | 1 | Terminal count from the host |
| tc_core_o | output | 1 | Gated terminal count to the core |

## Verification
The results appear at three different times after a stimulus. `rdata_o` and `core_rst_no` change at the edge that samples the write. `drv_sel_no` and `motor_no` change one edge after that, through the output flops. The gating outputs follow the mode, the DMA bit and the gated inputs within the same cycle. The bench reference model advances on each rising edge and keeps its own one-stage delay for the pin outputs. All outputs are compared at the falling edge, and inputs change just after that edge, so each comparison sees settled values for the correct cycle.

// File: rtl/fdc_dor_pkg.sv
`timescale 1ns/1ps
package fdc_dor_pkg;
  typedef enum logic {
    MODE_AT  = 1'b0,
    MODE_PS2 = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic drq;
    logic drq_oe;
    logic intr;
    logic intr_oe;
    logic dack_n;
    logic tc;
  } gate_out_t;

  function automatic int unsigned sel_width(int unsigned drives);
    return (drives > 1) ? $clog2(drives) : 1;
  endfunction
endpackage

// File: rtl/fdc_dor_reg.sv
`timescale 1ns/1ps
module fdc_dor_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  // only hardware reset clears the register; soft reset has no path here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/fdc_dor_drive_out.sv
`timescale 1ns/1ps
module fdc_dor_drive_out #(
  parameter int unsigned NUM_DRIVES = 4,
  parameter int unsigned SEL_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM_DRIVES-1:0] motor_i,
  output logic [NUM_DRIVES-1:0] drv_sel_no,
  output logic [NUM_DRIVES-1:0] motor_no
);
  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    localparam logic SEL_RST = (g == 0) ? 1'b0 : 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drv_sel_no[g] <= SEL_RST;
        motor_no[g]   <= 1'b1;
      end else begin
        drv_sel_no[g] <= ~(sel_i == SEL_W'(g));
        motor_no[g]   <= ~motor_i[g];
      end
    end
  end
endmodule

// File: rtl/fdc_dor_gate.sv
`timescale 1ns/1ps
module fdc_dor_gate
  import fdc_dor_pkg::*;
(
  input  bus_mode_e mode_i,
  input  logic      dma_en_i,
  input  logic      drq_i,
  input  logic      int_i,
  input  logic      dack_ni,
  input  logic      tc_i,
  output gate_out_t gate_o
);
  logic open_w;

  assign open_w = (mode_i == MODE_PS2) | dma_en_i;

  always_comb begin
    gate_o.drq     = open_w & drq_i;
    gate_o.drq_oe  = open_w;
    gate_o.intr    = open_w & int_i;
    gate_o.intr_oe = open_w;
    gate_o.dack_n  = open_w ? dack_ni : 1'b1;
    gate_o.tc      = open_w & tc_i;
  end
endmodule

// File: rtl/fdc_drive_ctl.sv
`timescale 1ns/1ps
module fdc_drive_ctl
  import fdc_dor_pkg::*;
#(
  parameter int unsigned NUM_DRIVES = 4,
  localparam int unsigned SEL_W     = sel_width(NUM_DRIVES),
  localparam int unsigned REG_W     = SEL_W + 2 + NUM_DRIVES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ps2_mode_i,
  input  logic                  wr_en_i,
  input  logic [REG_W-1:0]      wdata_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic                  core_rst_no,
  output logic [NUM_DRIVES-1:0] drv_sel_no,
  output logic [NUM_DRIVES-1:0] motor_no,
  input  logic                  drq_i,
  output logic                  drq_o,
  output logic                  drq_oe_o,
  input  logic                  int_i,
  output logic                  int_o,
  output logic                  int_oe_o,
  input  logic                  dack_ni,
  output logic                  dack_core_no,
  input  logic                  tc_i,
  output logic                  tc_core_o
);
  localparam int unsigned RST_BIT = SEL_W;
  localparam int unsigned DMA_BIT = SEL_W + 1;
  localparam int unsigned MTR_LSB = SEL_W + 2;

  logic [REG_W-1:0] ctl_q;
  gate_out_t        gate;

  fdc_dor_reg #(.W(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .q_o     (ctl_q)
  );

  fdc_dor_drive_out #(.NUM_DRIVES(NUM_DRIVES), .SEL_W(SEL_W)) u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (ctl_q[SEL_W-1:0]),
    .motor_i    (ctl_q[MTR_LSB +: NUM_DRIVES]),
    .drv_sel_no (drv_sel_no),
    .motor_no   (motor_no)
  );

  fdc_dor_gate u_gate (
    .mode_i   (bus_mode_e'(ps2_mode_i)),
    .dma_en_i (ctl_q[DMA_BIT]),
    .drq_i    (drq_i),
    .int_i    (int_i),
    .dack_ni  (dack_ni),
    .tc_i     (tc_i),
    .gate_o   (gate)
  );

  assign rdata_o      = ctl_q;
  assign core_rst_no  = ctl_q[RST_BIT];
  assign drq_o        = gate.drq;
  assign drq_oe_o     = gate.drq_oe;
  assign int_o        = gate.intr;
  assign int_oe_o     = gate.intr_oe;
  assign dack_core_no = gate.dack_n;
  assign tc_core_o    = gate.tc;
endmodule

// File: rtl/fdc_drive_ctl_chk.sv
`timescale 1ns/1ps
module fdc_drive_ctl_chk #(
  parameter int unsigned NUM_DRIVES = 4,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned REG_W      = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ps2_mode_i,
  input logic                  wr_en_i,
  input logic [REG_W-1:0]      wdata_i,
  input logic [REG_W-1:0]      rdata_o,
  input logic                  core_rst_no,
  input logic [NUM_DRIVES-1:0] drv_sel_no,
  input logic [NUM_DRIVES-1:0] motor_no,
  input logic                  drq_oe_o,
  input logic                  int_oe_o,
  input logic                  dack_core_no,
  input logic                  tc_core_o
);
  // R2
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rdata_o == $past(wdata_i));

  // R6
  hold_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rdata_o));

  // R5
  soft_rst_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> core_rst_no == $past(wdata_i[SEL_W]));

  // R3
  one_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~drv_sel_no) == 1);

  // R3
  sel_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~drv_sel_no) == (NUM_DRIVES'(1) << $past(rdata_o[SEL_W-1:0])));

  // R4
  motor_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> motor_no == ~$past(rdata_o[REG_W-1 -: NUM_DRIVES]));

  // R8
  ps2_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps2_mode_i |-> drq_oe_o && int_oe_o);

  // R7
  at_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ps2_mode_i && !rdata_o[SEL_W+1]) |-> (!drq_oe_o && !int_oe_o && dack_core_no && !tc_core_o));
endmodule

bind fdc_drive_ctl fdc_drive_ctl_chk #(
  .NUM_DRIVES (NUM_DRIVES),
  .SEL_W      (SEL_W),
  .REG_W      (REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ps2_mode_i   (ps2_mode_i),
  .wr_en_i      (wr_en_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .core_rst_no  (core_rst_no),
  .drv_sel_no   (drv_sel_no),
  .motor_no     (motor_no),
  .drq_oe_o     (drq_oe_o),
  .int_oe_o     (int_oe_o),
  .dack_core_no (dack_core_no),
  .tc_core_o    (tc_core_o)
);

// File: tb/fdc_drive_ctl_bench.sv
`timescale 1ns/1ps
module fdc_drive_ctl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ps2_mode_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       core_rst_no;
  logic [3:0] drv_sel_no, motor_no;
  logic       drq_i = 1'b0, int_i = 1'b0, dack_ni = 1'b1, tc_i = 1'b0;
  logic       drq_o, drq_oe_o, int_o, int_oe_o, dack_core_no, tc_core_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  fdc_drive_ctl u_fdc_drive_ctl (
    .clk_i, .rst_ni, .ps2_mode_i, .wr_en_i, .wdata_i, .rdata_o, .core_rst_no,
    .drv_sel_no, .motor_no, .drq_i, .drq_o, .drq_oe_o, .int_i, .int_o, .int_oe_o,
    .dack_ni, .dack_core_no, .tc_i, .tc_core_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: register and one-stage pin delay
  int ref_reg = 0;
  int ref_pin = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_reg = 0;
      ref_pin = 0;
    end else begin
      ref_pin = ref_reg;
      if (wr_en_i) ref_reg = int'(wdata_i);
    end
  end

  always @(negedge clk_i) begin
    bit open;
    int n;
    if (!done) begin
      n = ref_pin & 3;
      open = ps2_mode_i || ((ref_reg >> 3) & 1) != 0;
      if (!rst_ni) check("R1 rdata", 32'(rdata_o), 32'(ref_reg));
      else         check("R2 rdata", 32'(rdata_o), 32'(ref_reg));
      check("R5 core_rst", 32'(core_rst_no), 32'((ref_reg >> 2) & 1));
      check("R3 drv_sel", 32'(drv_sel_no), 32'(~(1 << n) & 15));
      check("R4 motor", 32'(motor_no), 32'(~(ref_pin >> 4) & 15));
      if (ps2_mode_i) begin
        check("R8 drq_oe", 32'(drq_oe_o), 32'(open));
        check("R8 int_oe", 32'(int_oe_o), 32'(open));
      end else begin
        check("R7 drq_oe", 32'(drq_oe_o), 32'(open));
        check("R7 int_oe", 32'(int_oe_o), 32'(open));
      end
      check("R7 drq", 32'(drq_o), 32'(open && drq_i));
      check("R7 int", 32'(int_o), 32'(open && int_i));
      check("R7 dack", 32'(dack_core_no), 32'(open ? dack_ni : 1'b1));
      check("R7 tc", 32'(tc_core_o), 32'(open && tc_i));
    end
  end

  task automatic drive(bit wr, logic [7:0] d);
    @(negedge clk_i);
    #1;
    wr_en_i = wr;
    wdata_i = d;
    drq_i   = 1'($urandom);
    int_i   = 1'($urandom);
    dack_ni = 1'($urandom);
    tc_i    = 1'($urandom);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) drive(0, 8'h00);
    @(negedge clk_i);
    check("R1 rst rdata", 32'(rdata_o), 32'h00);
    check("R1 rst core", 32'(core_rst_no), 32'h0);
    check("R1 rst sel", 32'(drv_sel_no), 32'hE);
    check("R1 rst motor", 32'(motor_no), 32'hF);
    #1 rst_ni = 1'b1;

    // R2: write while soft reset asserted
    drive(1, 8'h38);
    drive(0, 8'h00);
    check("R2 write in soft rst", 32'(rdata_o), 32'h38);

    // R9: canonical drive/motor bytes
    for (int i = 0; i < 4; i++) begin
      drive(1, 8'((8'h10 << i) | 8'h0C | i));
      drive(0, 8'h00);
      drive(0, 8'h00);
      check("R9 sel", 32'(drv_sel_no), 32'(~(1 << i) & 15));
      check("R9 motor", 32'(motor_no), 32'(~(1 << i) & 15));
      check("R9 core", 32'(core_rst_no), 32'h1);
      check("R9 dma", 32'(drq_oe_o), 32'h1);
    end

    // R6: soft reset keeps other bits
    drive(1, 8'h4A);
    for (int i = 0; i < 4; i++) begin
      drive(0, 8'h00);
      check("R6 hold rdata", 32'(rdata_o), 32'h4A);
      check("R6 hold core", 32'(core_rst_no), 32'h0);
    end
    check("R6 motor kept", 32'(motor_no), 32'hB);
    drive(1, 8'h08);
    drive(1, 8'h0C);
    drive(0, 8'h00);
    check("R6 pulse end", 32'(core_rst_no), 32'h1);

    // R7: AT mode, DMA off then random traffic
    drive(1, 8'h04);
    repeat (8) drive(0, 8'h00);
    repeat (300) drive(($urandom % 3) == 0, 8'($urandom));

    // R8: PS/2 mode, including hardware reset
    ps2_mode_i = 1'b1;
    drive(1, 8'h0C);
    repeat (300) drive(($urandom % 3) == 0, 8'($urandom));
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    drive(0, 8'h00);
    check("R8 oe in hw rst", 32'(drq_oe_o), 32'h1);
    check("R8 dma bit cleared", 32'(rdata_o[3]), 32'h0);
    #1 rst_ni = 1'b1;
    drive(1, 8'h05);
    repeat (4) drive(0, 8'h00);
    check("R8 dma off still open", 32'(int_oe_o), 32'h1);

    ps2_mode_i = 1'b0;
    repeat (200) drive(($urandom % 3) == 0, 8'($urandom));
    drive(0, 8'h00);
    finish_run();
  end
endmodule